// File: doc/BRIEF.md
# Preloadable Up-Counting Interval Timer

The block is a 16-bit interval timer that advances once for each cycle in which the `tick` enable is high. Software places a start value in a preload register. The count then runs upward from that value. When it passes 0xFFFF it takes the preload value again, which sets the interrupt period to 0x10000 minus the preload, counted in ticks. Each wrap adds one to a saturating four-bit overflow tally and sets an interrupt pending flag.

Software reaches the block through a byte-wide register port. Control is a three-bit code, and its bits decode into four actions: clear, arm (load), hold, and run. The interrupt-control register holds the pending flag, an enable and a three-bit level. The request output goes out together with its level. That level is zero whenever no request is active.

Top module: `interval_timer`

## Requirements
- R1: After reset, every register reads 0x00 at offsets 0 to 5, `irq` is low and `irqLevel` is 0.
- R2: Preload high byte is written and read at offset 0 and the low byte at offset 1; the count high byte reads at offset 2 and the count low byte at offset 3, two bytes above the preload.
- R3: A write to offset 4 whose bit 0 is 0 (for example code 0x0) clears the count and the tally to 0 and stops counting; offset 4 reads back {tally[3:0] in bits 7:4, 0 in bit 3, last written code in bits 2:0}.
- R4: A write to offset 4 with bit 0 = 1 and bit 1 = 0 (for example code 0x1) loads the count from the preload and leaves it holding.
- R5: A code with bits 1:0 = 11 and bit 2 = 0 (code 0x3) stops counting and keeps the current count.
- R6: With code 0x7 (all three bits set) in force, the count rises by one in each cycle where `tick` is high and does not change when `tick` is low.
- R7: In a running timer at 0xFFFF, a tick reloads the count from the preload in that same clock, so one interrupt period spans 0x10000 minus the preload in ticks (16 ticks for preload 0xFFF0).
- R8: Each wrap increments the tally in bits 7:4 of offset 4; it saturates at 15 and returns to 0 only through a clear code.
- R9: At offset 5, bit 7 reads as the pending flag, which a wrap sets and a write with bit 7 = 1 clears (a wrap in the same clock wins); bit 3 is the enable and bits 2:0 the level, both written and read back.
- R10: `irq` is high exactly when pending and enable are both 1 and the level is nonzero; `irqLevel` equals the level while `irq` is high and is 0 otherwise.
- R11: A read of offset 2 captures the count's low byte at that clock; a later read of offset 3 returns the captured byte, even if ticks have moved the count since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase count enable, one clock per tick |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register byte offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |
| irqLevel | output | 3 | Level of the active request, 0 when idle |

## Verification
Several properties are checked on every cycle. After a wrap the count must equal the preload. A count with no tick and no load must not change. A saturated tally must stay saturated until a clear. The pending flag may rise only on a wrap. The captured low byte may change only on a high-byte read, and the request and its level must always agree. Some behaviour shows up only in the bench scenarios, which compare against the reference model. These are the exact interrupt period for a given preload, the meaning of each control code, tally saturation over many wraps, acknowledge, and masking by level 0. They also include the byte placement of the registers and the value captured for the low byte while the count is moving.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam logic [2:0] A_PRE_HI = 3'd0;
  localparam logic [2:0] A_PRE_LO = 3'd1;
  localparam logic [2:0] A_CNT_HI = 3'd2;
  localparam logic [2:0] A_CNT_LO = 3'd3;
  localparam logic [2:0] A_MODE   = 3'd4;
  localparam logic [2:0] A_ICTL   = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic       clr;
    logic       arm;
    logic       run;
    logic       preHiWr;
    logic       preLoWr;
    logic       snap;
    logic [7:0] wrByte;
  } strobe_t;
endpackage

// File: rtl/itmr_datapath.sv
module itmr_datapath
  import itmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TALLY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  strobe_t            stb,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   preload,
  output logic [TALLY_W-1:0] tally,
  output logic [7:0]         snapLo,
  output logic               wrap
);
  localparam logic [CNT_W-1:0]   CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]   CNT_ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [TALLY_W-1:0] TALLY_MAX = {TALLY_W{1'b1}};
  localparam logic [TALLY_W-1:0] TALLY_ONE = {{(TALLY_W-1){1'b0}}, 1'b1};

  logic atTop;
  logic stepEn;

  assign atTop  = (count == CNT_MAX);
  assign stepEn = stb.run && tick && !stb.clr && !stb.arm;
  assign wrap   = stepEn && atTop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preload <= '0;
    end else begin
      if (stb.preHiWr) preload[CNT_W-1:8] <= stb.wrByte;
      if (stb.preLoWr) preload[7:0]       <= stb.wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (stb.clr) begin
      count <= '0;
    end else if (stb.arm) begin
      count <= preload;
    end else if (stepEn) begin
      count <= atTop ? preload : count + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tally <= '0;
    end else if (stb.clr) begin
      tally <= '0;
    end else if (wrap && tally != TALLY_MAX) begin
      tally <= tally + TALLY_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapLo <= '0;
    end else if (stb.snap) begin
      snapLo <= count[7:0];
    end
  end
endmodule

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TALLY_W = 4,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [2:0]         addr,
  input  logic [7:0]         wrData,
  input  logic               wrap,
  input  logic [CNT_W-1:0]   count,
  input  logic [CNT_W-1:0]   preload,
  input  logic [TALLY_W-1:0] tally,
  input  logic [7:0]         snapLo,
  output strobe_t            stb,
  output logic [7:0]         rdData,
  output logic               pending,
  output logic               irq,
  output logic [LVL_W-1:0]   irqLevel
);
  logic [2:0]       modeReg;
  logic             ienReg;
  logic [LVL_W-1:0] lvlReg;
  logic             modeWr;
  logic             ictlWr;
  logic [7:0]       modeByte;
  logic [7:0]       ictlByte;

  assign modeWr = wrEn && addr == A_MODE;
  assign ictlWr = wrEn && addr == A_ICTL;

  always_comb begin
    stb.clr     = modeWr && !wrData[0];
    stb.arm     = modeWr && wrData[0] && !wrData[1];
    stb.run     = &modeReg;
    stb.preHiWr = wrEn && addr == A_PRE_HI;
    stb.preLoWr = wrEn && addr == A_PRE_LO;
    stb.snap    = rdEn && addr == A_CNT_HI;
    stb.wrByte  = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       modeReg <= '0;
    else if (modeWr) modeReg <= wrData[2:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienReg <= 1'b0;
      lvlReg <= '0;
    end else if (ictlWr) begin
      ienReg <= wrData[3];
      lvlReg <= wrData[LVL_W-1:0];
    end
  end

  // a wrap in the acknowledge clock keeps the flag set
  always_ff @(posedge clk) begin
    if (!rstN)                      pending <= 1'b0;
    else if (wrap)                  pending <= 1'b1;
    else if (ictlWr && wrData[7])   pending <= 1'b0;
  end

  assign irq      = pending && ienReg && (lvlReg != '0);
  assign irqLevel = irq ? lvlReg : '0;

  always_comb begin
    modeByte      = '0;
    modeByte[7:4] = tally;
    modeByte[2:0] = modeReg;
    ictlByte              = '0;
    ictlByte[7]           = pending;
    ictlByte[3]           = ienReg;
    ictlByte[LVL_W-1:0]   = lvlReg;
  end

  always_comb begin
    case (addr)
      A_PRE_HI: rdData = preload[CNT_W-1:8];
      A_PRE_LO: rdData = preload[7:0];
      A_CNT_HI: rdData = count[CNT_W-1:8];
      A_CNT_LO: rdData = snapLo;
      A_MODE:   rdData = modeByte;
      A_ICTL:   rdData = ictlByte;
      default:  rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TALLY_W = 4,
  parameter int LVL_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [2:0]       addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output logic             irq,
  output logic [LVL_W-1:0] irqLevel
);
  strobe_t            stb;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   preload;
  logic [TALLY_W-1:0] tally;
  logic [7:0]         snapLo;
  logic               wrap;
  logic               pending;

  itmr_ctrl #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .wrap(wrap), .count(count), .preload(preload),
    .tally(tally), .snapLo(snapLo), .stb(stb), .rdData(rdData),
    .pending(pending), .irq(irq), .irqLevel(irqLevel)
  );

  itmr_datapath #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .stb(stb), .count(count),
    .preload(preload), .tally(tally), .snapLo(snapLo), .wrap(wrap)
  );
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker
  import itmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TALLY_W = 4,
  parameter int LVL_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               tick,
  input logic               rdEn,
  input logic [2:0]         addr,
  input strobe_t            stb,
  input logic [CNT_W-1:0]   count,
  input logic [CNT_W-1:0]   preload,
  input logic [TALLY_W-1:0] tally,
  input logic [7:0]         snapLo,
  input logic               wrap,
  input logic               pending,
  input logic               irq,
  input logic [LVL_W-1:0]   irqLevel
);
  localparam logic [TALLY_W-1:0] TALLY_MAX = {TALLY_W{1'b1}};

  a_r7_wrap_reload: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> count == $past(preload));

  a_r6_no_tick_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !stb.clr && !stb.arm) |=> $stable(count));

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (count == '0 && tally == '0));

  a_r8_tally_sat: assert property (@(posedge clk) disable iff (!rstN)
    (tally == TALLY_MAX && !stb.clr) |=> tally == TALLY_MAX);

  a_r9_pend_from_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(wrap));

  a_r10_level_active: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqLevel != '0 && pending));

  a_r10_level_idle: assert property (@(posedge clk) disable iff (!rstN)
    !irq |-> irqLevel == '0);

  a_r11_snap_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && addr == A_CNT_HI) |=> $stable(snapLo));
endmodule

bind interval_timer itmr_checker #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .rdEn(rdEn), .addr(addr), .stb(stb),
  .count(count), .preload(preload), .tally(tally), .snapLo(snapLo),
  .wrap(wrap), .pending(pending), .irq(irq), .irqLevel(irqLevel)
);

// File: tb/tb_interval_timer.sv
`timescale 1ns/1ps
module tb_interval_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irq;
  logic [2:0] irqLevel;

  int total = 0;
  int bad = 0;
  bit tickOn = 1'b0;
  bit done = 1'b0;

  // reference model state
  int mCount, mPre, mTally, mMode, mPend, mIen, mLvl, mSnap;
  int mWrap;

  always #2 clk = ~clk;

  interval_timer dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq), .irqLevel(irqLevel)
  );

  always @(negedge clk) tick = tickOn;

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mPre = 0; mTally = 0; mMode = 0;
      mPend = 0; mIen = 0; mLvl = 0; mSnap = 0;
    end else begin
      mWrap = 0;
      if (rdEn && addr == 3'd2) mSnap = mCount % 256;
      if (wrEn && addr == 3'd4 && !wrData[0]) begin
        mCount = 0; mTally = 0;
      end else if (wrEn && addr == 3'd4 && wrData[1:0] == 2'b01) begin
        mCount = mPre;
      end else if (mMode == 7 && tick) begin
        if (mCount == 65535) begin
          mCount = mPre; mWrap = 1;
          if (mTally < 15) mTally = mTally + 1;
        end else mCount = mCount + 1;
      end
      if (mWrap != 0) mPend = 1;
      else if (wrEn && addr == 3'd5 && wrData[7]) mPend = 0;
      if (wrEn && addr == 3'd5) begin mIen = wrData[3]; mLvl = wrData[2:0]; end
      if (wrEn && addr == 3'd4) mMode = wrData[2:0];
      if (wrEn && addr == 3'd0) mPre = (mPre % 256) + wrData * 256;
      if (wrEn && addr == 3'd1) mPre = (mPre / 256) * 256 + wrData;
    end
  end

  function automatic int modelRead(input int a);
    case (a)
      0: return mPre / 256;
      1: return mPre % 256;
      2: return mCount / 256;
      3: return mSnap;
      4: return mTally * 16 + mMode;
      5: return mPend * 128 + mIen * 8 + mLvl;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison of the request outputs
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(irq, (mPend && mIen && mLvl != 0) ? 1 : 0, "R10 irq");
      chk(irqLevel, (mPend && mIen && mLvl != 0) ? mLvl : 0, "R10 irqLevel");
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; addr = a[2:0]; wrData = d[7:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input int a, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a[2:0];
    #1;
    chk(rdData, modelRead(a), tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdLit(input int a, input int exp, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a[2:0];
    #1;
    chk(rdData, exp, tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int firstHi;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    for (int a = 0; a < 6; a++) rdLit(a, 0, "R1 reset reg");
    chk(irq, 0, "R1 irq");
    // R2 preload byte placement
    wr(0, 8'hFF); wr(1, 8'hF0);
    rdLit(0, 8'hFF, "R2 preload hi");
    rdLit(1, 8'hF0, "R2 preload lo");
    // R4 arm with code 0x1, tick running
    tickOn = 1'b1;
    wr(4, 1);
    idle(3);
    rdLit(2, 8'hFF, "R4 count hi");
    rdLit(3, 8'hF0, "R4 count lo via R11 capture");
    rdLit(4, 8'h01, "R3 mode readback");
    // R6 run, then R5 stop
    wr(4, 7);
    idle(4);
    wr(4, 3);
    rdChk(2, "R5 count hi");
    firstHi = mCount;
    rdChk(3, "R5 count lo");
    idle(5);
    chk(mCount, firstHi, "R5 model hold");
    rdChk(2, "R5 count hi after wait");
    rdChk(3, "R5 count lo after wait");
    // R6 running without tick holds
    tickOn = 1'b0;
    wr(4, 7);
    idle(6);
    rdChk(2, "R6 no tick hi");
    rdChk(3, "R6 no tick lo");
    tickOn = 1'b1;
    idle(2);
    rdChk(2, "R6 tick hi");
    rdChk(3, "R6 tick lo");
    // R7 period measurement with preload 0xFFF0
    wr(5, 8'h0B);
    wr(4, 0);
    wr(4, 1);
    wr(5, 8'h8B);
    chk(irq, 0, "R9 ack before run");
    wr(4, 7);
    n = 0;
    while (!irq && n < 100) begin @(negedge clk); n++; end
    chk(n, 16, "R7 period ticks");
    chk(irqLevel, 3, "R10 level out");
    rdLit(5, 8'h8B, "R9 pending readback");
    rdChk(4, "R8 tally one");
    // R9 acknowledge
    wr(4, 3);
    wr(5, 8'h8B);
    chk(irq, 0, "R9 irq after ack");
    rdLit(5, 8'h0B, "R9 pending cleared");
    // R10 level zero masks request
    wr(5, 8'h08);
    wr(4, 7);
    idle(40);
    rdChk(5, "R10 pending with level 0");
    chk(irq, 0, "R10 masked by level 0");
    // R8 saturation with preload 0xFFFE
    wr(4, 0);
    rdLit(2, 0, "R3 clear count hi");
    rdLit(4, 0, "R3 clear tally");
    wr(1, 8'hFE);
    wr(4, 1);
    wr(4, 7);
    idle(60);
    rdLit(4, 8'hF7, "R8 tally saturated");
    idle(10);
    rdLit(4, 8'hF7, "R8 tally stays");
    // R11 capture while moving (preload 0xFF00, long period)
    wr(1, 8'h00);
    wr(4, 1);
    wr(4, 7);
    idle(7);
    rdChk(2, "R11 hi read");
    idle(3);
    rdChk(3, "R11 lo captured");
    rdChk(2, "R11 hi second");
    rdChk(3, "R11 lo second");
    wr(4, 0);
    rdLit(4, 0, "R3 final clear");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule